// File: doc/BRIEF.md
# Switching Frequency Standby Detector

This block decides whether a secondary-side synchronous rectifier should keep switching or drop into a low-power standby state. It watches a single logic input that goes high at the start of each primary conduction interval. It counts the rising edges of that input, one edge per switching cycle, inside fixed time windows. Load level is judged only from switching frequency. A light load makes the primary switch less often, so too few cycles in a window means the converter is lightly loaded.

In run mode the block uses a long observation window and needs a minimum number of cycles in each one. If a window closes with fewer, the block enters standby and forces the gate-drive enable low. In standby it uses a shorter window and a smaller cycle target. It returns to run at once when that target is reached inside one short window. The different window lengths and thresholds give hysteresis in the time domain, so the block does not chatter between states near the boundary load. Window lengths are set in microseconds and turned into clock counts from a clock-frequency parameter. That parameter must be a whole multiple of 1 MHz.

Top module: `sfsd_standby_detect`

## Requirements
- R1: On reset the block is in run mode: `standby` is 0, `drive_en` is 1, and both the window position and the cycle count are cleared.
- R2: In run mode the window lasts ENTER_LEN = (CLK_HZ / 1,000,000) × ENTER_SPAN_US clocks. On the clock edge that ends a run window, if fewer than ENTER_MIN_CYCLES edges were counted in it, `standby` becomes 1 after that edge.
- R3: A run window that ends with ENTER_MIN_CYCLES or more counted edges leaves the block in run mode. The cycle count saturates and does not wrap back below the threshold.
- R4: In standby the window lasts EXIT_LEN = (CLK_HZ / 1,000,000) × EXIT_SPAN_US clocks. `standby` returns to 0 on the same clock edge at which the EXIT_MIN_CYCLES-th edge of the current standby window is counted, without waiting for the window to end.
- R5: `drive_en` is 1 exactly when `standby` is 0. In standby the drive stays disabled whatever the input does.
- R6: The cycle count restarts at every window boundary. Edges counted in one window never add to the next window.
- R7: On every change of state, the window position and the cycle count restart from zero. The first window of the new state is a full window measured from the change.
- R8: Only rising edges are counted, so a level held high counts once. With SYNC_STAGES = 2, a high level first sampled on `pc_in` at clock edge k is counted at clock edge k+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_in | input | 1 | Primary conduction indicator; one rising edge per switching cycle (asynchronous) |
| standby | output | 1 | 1 while the block is in the low-power standby state |
| drive_en | output | 1 | Gate-drive enable; 0 while in standby |

## Verification
The bench builds the block with CLK_HZ = 1 MHz, a 200 µs run window, a 50 µs standby window, and thresholds of 8 and 4 cycles. These values let many complete run and standby windows, and several state changes, fit in about a thousand clocks. With them the bench can hit the exact threshold boundary (7 against 8 edges), edges that straddle a standby window boundary, a wake-up in the middle of a window, and the realignment of windows after each state change, all at exact clock edges. The defaults (20 MHz, 12.8 ms, 2.56 ms, 64 and 32 cycles) use the same logic with wider counters.

// File: rtl/sfsd_pkg.sv
package sfsd_pkg;

  typedef enum logic {
    MODE_RUN   = 1'b0,
    MODE_SLEEP = 1'b1
  } mode_e;

  // Converts a span in microseconds into clock periods (clk_hz a multiple of 1 MHz).
  function automatic int unsigned us_to_clocks(input int unsigned clk_hz,
                                               input int unsigned span_us);
    return (clk_hz / 32'd1_000_000) * span_us;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sfsd_edge_detect.sv
module sfsd_edge_detect #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pc_in,
  output logic rise
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pc_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pc_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~last_q;

endmodule

// File: rtl/sfsd_window_timer.sv
module sfsd_window_timer #(
  parameter int unsigned RUN_LEN   = 256000,
  parameter int unsigned SLEEP_LEN = 51200,
  parameter int unsigned W         = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         sleep,
  output logic         win_end,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] RUN_LAST   = W'(RUN_LEN - 1);
  localparam logic [W-1:0] SLEEP_LAST = W'(SLEEP_LEN - 1);

  assign win_end = sleep ? (count == SLEEP_LAST) : (count == RUN_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 count <= '0;
    else if (restart || win_end) count <= '0;
    else                        count <= count + W'(1);
  end

endmodule

// File: rtl/sfsd_cycle_counter.sv
module sfsd_cycle_counter #(
  parameter int unsigned MAX = 64,
  parameter int unsigned W   = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         inc,
  output logic [W-1:0] count,
  output logic [W:0]   total
);

  localparam logic [W-1:0] SAT = W'(MAX);

  assign total = {1'b0, count} + (W+1)'(inc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   count <= '0;
    else if (clear)               count <= '0;
    else if (inc && count != SAT) count <= count + W'(1);
  end

endmodule

// File: rtl/sfsd_mode_ctrl.sv
module sfsd_mode_ctrl
  import sfsd_pkg::*;
#(
  parameter int unsigned ENTER_MIN = 64,
  parameter int unsigned EXIT_MIN  = 32,
  parameter int unsigned TW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] total,
  input  logic          win_end,
  output mode_e         mode,
  output logic          change
);

  localparam logic [TW-1:0] ENTER_TH = TW'(ENTER_MIN);
  localparam logic [TW-1:0] EXIT_TH  = TW'(EXIT_MIN);

  always_comb begin
    unique case (mode)
      MODE_RUN:   change = win_end && (total < ENTER_TH);
      MODE_SLEEP: change = (total >= EXIT_TH);
      default:    change = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mode <= MODE_RUN;
    else if (change) mode <= (mode == MODE_RUN) ? MODE_SLEEP : MODE_RUN;
  end

endmodule

// File: rtl/sfsd_standby_detect.sv
module sfsd_standby_detect
  import sfsd_pkg::*;
#(
  parameter int unsigned CLK_HZ           = 20_000_000,
  parameter int unsigned ENTER_SPAN_US    = 12800,
  parameter int unsigned EXIT_SPAN_US     = 2560,
  parameter int unsigned ENTER_MIN_CYCLES = 64,
  parameter int unsigned EXIT_MIN_CYCLES  = 32,
  parameter int unsigned SYNC_STAGES      = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pc_in,
  output logic standby,
  output logic drive_en
);

  localparam int unsigned ENTER_LEN = us_to_clocks(CLK_HZ, ENTER_SPAN_US);
  localparam int unsigned EXIT_LEN  = us_to_clocks(CLK_HZ, EXIT_SPAN_US);
  localparam int unsigned WIN_W     = $clog2(max_u(ENTER_LEN, EXIT_LEN) + 1);
  localparam int unsigned CNT_MAX   = max_u(ENTER_MIN_CYCLES, EXIT_MIN_CYCLES);
  localparam int unsigned CNT_W     = $clog2(CNT_MAX + 1);

  logic             pc_edge;
  logic             win_end;
  logic [WIN_W-1:0] win_cnt;
  logic [CNT_W-1:0] cyc_cnt;
  logic [CNT_W:0]   cyc_total;
  logic             mode_change;
  mode_e            mode;

  sfsd_edge_detect #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .pc_in(pc_in),
    .rise (pc_edge)
  );

  sfsd_window_timer #(
    .RUN_LEN  (ENTER_LEN),
    .SLEEP_LEN(EXIT_LEN),
    .W        (WIN_W)
  ) u_window (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(mode_change),
    .sleep  (mode == MODE_SLEEP),
    .win_end(win_end),
    .count  (win_cnt)
  );

  sfsd_cycle_counter #(
    .MAX(CNT_MAX),
    .W  (CNT_W)
  ) u_cycles (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(win_end | mode_change),
    .inc  (pc_edge),
    .count(cyc_cnt),
    .total(cyc_total)
  );

  sfsd_mode_ctrl #(
    .ENTER_MIN(ENTER_MIN_CYCLES),
    .EXIT_MIN (EXIT_MIN_CYCLES),
    .TW       (CNT_W + 1)
  ) u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .total  (cyc_total),
    .win_end(win_end),
    .mode   (mode),
    .change (mode_change)
  );

  assign standby  = (mode == MODE_SLEEP);
  assign drive_en = (mode == MODE_RUN);

endmodule

// File: rtl/sfsd_checker.sv
module sfsd_checker #(
  parameter int unsigned ENTER_LEN = 256000,
  parameter int unsigned EXIT_LEN  = 51200,
  parameter int unsigned CNT_MAX   = 64,
  parameter int unsigned WIN_W     = 18,
  parameter int unsigned CNT_W     = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             standby,
  input logic             drive_en,
  input logic             pc_edge,
  input logic [WIN_W-1:0] win_cnt,
  input logic [CNT_W-1:0] cyc_cnt
);

  localparam logic [WIN_W-1:0] ENTER_LAST = WIN_W'(ENTER_LEN - 1);
  localparam logic [WIN_W-1:0] EXIT_LAST  = WIN_W'(EXIT_LEN - 1);
  localparam logic [CNT_W-1:0] CNT_TOP    = CNT_W'(CNT_MAX);

  // R5: drive enable is the inverse of standby
  a_r5_drive_follows_mode: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en == !standby);

  // R2: standby is only entered at the end of a run window
  a_r2_enter_on_window_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(standby) |-> $past(win_cnt) == ENTER_LAST);

  // R4: leaving standby needs an edge counted on that clock
  a_r4_exit_on_counted_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(standby) |-> $past(pc_edge));

  // R7: both counters restart on a state change
  a_r7_restart_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    (standby != $past(standby)) |-> (win_cnt == '0 && cyc_cnt == '0));

  // R6: the window position stays inside the current mode's window
  a_r6_window_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    standby ? (win_cnt <= EXIT_LAST) : (win_cnt <= ENTER_LAST));

  // R3: the cycle count saturates rather than wrapping
  a_r3_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_cnt <= CNT_TOP);

endmodule

bind sfsd_standby_detect sfsd_checker #(
  .ENTER_LEN(ENTER_LEN),
  .EXIT_LEN (EXIT_LEN),
  .CNT_MAX  (CNT_MAX),
  .WIN_W    (WIN_W),
  .CNT_W    (CNT_W)
) u_sfsd_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .standby (standby),
  .drive_en(drive_en),
  .pc_edge (pc_edge),
  .win_cnt (win_cnt),
  .cyc_cnt (cyc_cnt)
);

// File: tb/sfsd_standby_detect_test.sv
module sfsd_standby_detect_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  typedef struct {
    int    cyc;
    bit    sb;
    string tag;
  } exp_t;

  logic clk   = 1'b0;
  logic rst_n = 1'b0;
  logic pc_in = 1'b0;
  logic standby;
  logic drive_en;

  int   pcyc;
  int   checks   = 0;
  int   failures = 0;
  bit   done     = 1'b0;
  exp_t sb_q[$];

  sfsd_standby_detect #(
    .CLK_HZ          (1_000_000),
    .ENTER_SPAN_US   (200),
    .EXIT_SPAN_US    (50),
    .ENTER_MIN_CYCLES(8),
    .EXIT_MIN_CYCLES (4),
    .SYNC_STAGES     (2)
  ) uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .pc_in   (pc_in),
    .standby (standby),
    .drive_en(drive_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Number of rising clock edges since reset release.
  always @(posedge clk) begin
    if (!rst_n) pcyc <= 0;
    else        pcyc <= pcyc + 1;
  end

  task automatic check_eq(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", tag, what, pcyc, act, exp);
    end
  endtask

  task automatic expect_at(input int c, input bit sb, input string tag);
    exp_t it;
    it.cyc = c;
    it.sb  = sb;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Raise pc_in so that its rising edge is counted at clock edge c (R8 latency).
  task automatic edge_at(input int c);
    do @(negedge clk); while (pcyc != c - 3);
    pc_in = 1'b1;
    @(negedge clk);
    pc_in = 1'b0;
  endtask

  // Monitor: pops expected items as their cycle comes up.
  always @(negedge clk) begin
    exp_t it;
    if (rst_n) begin
      while (sb_q.size() > 0 && sb_q[0].cyc == pcyc) begin
        it = sb_q.pop_front();
        check_eq(it.tag, "standby", int'(standby), int'(it.sb));
        check_eq({it.tag, "/R5"}, "drive_en", int'(drive_en), int'(!it.sb));
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired at cycle %0d: actual=running expected=finished", pcyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // Expected outcomes, ascending by cycle.
    expect_at(1,    1'b0, "R1");
    expect_at(150,  1'b0, "R3");
    expect_at(199,  1'b0, "R2");
    expect_at(200,  1'b0, "R3");   // exactly 8 edges keeps run
    expect_at(201,  1'b0, "R3");
    expect_at(399,  1'b0, "R2");
    expect_at(400,  1'b1, "R2");   // 7 edges -> standby
    expect_at(450,  1'b1, "R6");
    expect_at(451,  1'b1, "R6");
    expect_at(480,  1'b1, "R6");   // 3 + 3 split across boundary
    expect_at(500,  1'b1, "R6");
    expect_at(524,  1'b1, "R4");
    expect_at(525,  1'b0, "R4");   // 4th edge wakes mid-window
    expect_at(724,  1'b0, "R7");
    expect_at(725,  1'b1, "R7");   // window realigned to the change
    expect_at(735,  1'b1, "R8");
    expect_at(736,  1'b0, "R8");
    expect_at(936,  1'b0, "R3");   // saturated count, still run
    expect_at(1000, 1'b0, "R3");
    expect_at(1136, 1'b1, "R2");
    expect_at(1186, 1'b1, "R8");   // held level counts once
    expect_at(1187, 1'b1, "R8");

    repeat (3) @(negedge clk);
    check_eq("R1", "standby in reset", int'(standby), 0);
    check_eq("R1", "drive_en in reset", int'(drive_en), 1);
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++) edge_at(10 + 20*i);
    for (int i = 0; i < 7; i++) edge_at(210 + 20*i);
    for (int i = 0; i < 3; i++) edge_at(420 + 10*i);
    for (int i = 0; i < 3; i++) edge_at(460 + 10*i);
    for (int i = 0; i < 4; i++) edge_at(510 + 5*i);
    for (int i = 0; i < 4; i++) edge_at(730 + 2*i);
    for (int i = 0; i < 30; i++) edge_at(740 + 5*i);

    do @(negedge clk); while (pcyc != 1140);
    pc_in = 1'b1;
    do @(negedge clk); while (pcyc != 1180);
    pc_in = 1'b0;

    do @(negedge clk); while (pcyc < 1190);
    check_eq("R1", "pending expectations", sb_q.size(), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule